// File: doc/BRIEF.md
# Data-Path Scaling Shifter with Sign-Extension Mode

This block places a 16-bit word from the data bus onto a 32-bit arithmetic path. It shifts the word left by 0 to 16 places in the same cycle, with no register on the way. The vacated low bits become zeros. The bits above the word are filled in one of two ways: with copies of the word's top bit when sign extension is on, or with zeros when it is off.

A single registered mode bit chooses the fill. Each operation also has an override input that forces zero fill, whatever the mode bit says. The shift count comes from one of two sources, picked per operation by a select input. One source is a 5-bit immediate field. The other is the low five bits of a temporary register. Any count above 16 is treated as 16.

The mode bit has its own small update port, with set, clear and load-from-status-word inputs. Synchronous reset sets the mode bit to 1. The shift path always uses the mode value held at the start of the cycle.

Top module: `scaling_shifter`

## Requirements
- R1: `data_out` equals `data_in` shifted left by the effective count. Bits below the count are 0, and `data_in` appears unchanged at bit positions count through count+15.
- R2: When `sign_mode` is 1 and `force_zero` is 0, every bit of `data_out` above the shifted word equals `data_in[15]`.
- R3: When `sign_mode` is 0, every bit of `data_out` above the shifted word is 0.
- R4: When `force_zero` is 1, every bit above the shifted word is 0, whatever the value of `sign_mode`.
- R5: `cnt_src` = 0 takes the count from `imm_cnt`, and `cnt_src` = 1 takes it from `cnt_reg_lo`. The unselected source has no effect on `data_out`.
- R6: A selected count from 17 to 31 gives the same `data_out` as a count of 16.
- R7: A clock edge with `rst_n` low sets `sign_mode` to 1.
- R8: A clock edge with `mode_load` high copies `mode_load_val` into `sign_mode`, whatever `mode_set` and `mode_clr` are.
- R9: With `mode_load` low, an edge with `mode_set` high makes `sign_mode` 1. An edge with only `mode_clr` high makes it 0. When set and clear are both high, set wins.
- R10: An edge with none of `mode_load`, `mode_set` or `mode_clr` high leaves `sign_mode` unchanged.
- R11: `data_out` responds to input changes within the same cycle. It uses the `sign_mode` value held before the edge, so a mode update made in a cycle changes the fill only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode bit |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 16 | Word taken from the data bus |
| imm_cnt | input | 5 | Shift count from the immediate field |
| cnt_reg_lo | input | 5 | Low five bits of the temporary register |
| cnt_src | input | 1 | Count source: 0 immediate, 1 register |
| force_zero | input | 1 | Forces zero fill for this operation |
| mode_set | input | 1 | Sets the sign-extension mode bit |
| mode_clr | input | 1 | Clears the sign-extension mode bit |
| mode_load | input | 1 | Loads the mode bit from `mode_load_val` |
| mode_load_val | input | 1 | Mode value taken from the status word |
| data_out | output | 32 | Aligned 32-bit result |
| sign_mode | output | 1 | Current sign-extension mode bit |

## Verification
Two functions can fall in the same cycle: a mode update and a shift that depends on the mode.

The bench provokes this with sign extension on, a negative word and a zero count, while `mode_clr` is asserted. It samples `data_out` twice. Before the edge, the result must still be sign-filled. After the edge, it must be zero-filled, which shows the update took effect only from the next cycle.

Around this case, the bench sweeps every count from 0 to 31 through both count sources. It covers both mode values and both override settings, with several edge-case data words, and compares each result against an arithmetic model.

// File: rtl/ss_pkg.sv
// ss_pkg: shared sizes and types of the scaling shifter.
// Assumes: the output path is wider than the input word.
package ss_pkg;
    localparam int unsigned SS_DATA_W    = 16;
    localparam int unsigned SS_OUT_W     = 32;
    localparam int unsigned SS_CNT_W     = 5;
    localparam int unsigned SS_MAX_SHIFT = 16;

    // Source of the shift count for one operation.
    typedef enum logic {
        CNT_FROM_IMM = 1'b0,
        CNT_FROM_REG = 1'b1
    } cnt_src_e;

    // Update requested of the mode bit, in priority order.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SET   = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_op_e;
endpackage

// File: rtl/ss_mode_bit.sv
// ss_mode_bit: holds the sign-extension mode bit.
// Priority: reset, then load, then set, then clear. Set and clear together give set.
// Assumes: synchronous active-low reset.
module ss_mode_bit
    import ss_pkg::*;
#(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic load_i,
    input  logic load_val_i,
    output logic mode_o
);
    mode_op_e op;

    // Resolve the requested update by priority.
    always_comb begin
        if (load_i)     op = MODE_LOAD;
        else if (set_i) op = MODE_SET;
        else if (clr_i) op = MODE_CLEAR;
        else            op = MODE_HOLD;
    end

    // Register the mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= RESET_VAL;
        end else begin
            case (op)
                MODE_LOAD:  mode_o <= load_val_i;
                MODE_SET:   mode_o <= 1'b1;
                MODE_CLEAR: mode_o <= 1'b0;
                default:    mode_o <= mode_o;
            endcase
        end
    end
endmodule

// File: rtl/ss_count_sel.sv
// ss_count_sel: picks the shift count source and saturates it to MAX_SHIFT.
// Assumes: MAX_SHIFT fits in CNT_W bits.
module ss_count_sel
    import ss_pkg::*;
#(
    parameter int unsigned CNT_W     = SS_CNT_W,
    parameter int unsigned MAX_SHIFT = SS_MAX_SHIFT
) (
    input  cnt_src_e         src_i,
    input  logic [CNT_W-1:0] imm_i,
    input  logic [CNT_W-1:0] reg_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_SHIFT);
    logic [CNT_W-1:0] raw;

    // Select the count source.
    always_comb begin
        raw = (src_i == CNT_FROM_REG) ? reg_i : imm_i;
    end

    // Clamp the count to the largest legal shift.
    always_comb begin
        cnt_o = (raw > MAX_C) ? MAX_C : raw;
    end
endmodule

// File: rtl/ss_barrel.sv
// ss_barrel: widens the word with a given fill bit, then shifts it left in log stages.
// Assumes: the count is already clamped so that no data bit leaves the output.
module ss_barrel
    import ss_pkg::*;
#(
    parameter int unsigned DATA_W = SS_DATA_W,
    parameter int unsigned OUT_W  = SS_OUT_W,
    parameter int unsigned CNT_W  = SS_CNT_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              fill_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [OUT_W-1:0]  data_o
);
    localparam int unsigned EXT_W = OUT_W - DATA_W;

    logic [OUT_W-1:0] stage [CNT_W+1];

    // Widen the word: the fill goes above it.
    assign stage[0] = {{EXT_W{fill_i}}, data_i};

    // Each stage shifts by a power of two when its count bit is set.
    for (genvar i = 0; i < int'(CNT_W); i++) begin : g_stage
        assign stage[i+1] = cnt_i[i] ? (stage[i] << (2 ** i)) : stage[i];
    end

    assign data_o = stage[CNT_W];
endmodule

// File: rtl/scaling_shifter.sv
// scaling_shifter: aligns a data-bus word onto the wide arithmetic path in the same cycle.
// The fill above the word is sign or zero, chosen by the registered mode bit,
// and force_zero overrides it for one operation.
// Assumes: synchronous active-low reset; the shift path uses the mode bit held before the edge.
module scaling_shifter
    import ss_pkg::*;
#(
    parameter int unsigned DATA_W    = SS_DATA_W,
    parameter int unsigned OUT_W     = SS_OUT_W,
    parameter int unsigned CNT_W     = SS_CNT_W,
    parameter int unsigned MAX_SHIFT = SS_MAX_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  imm_cnt,
    input  logic [CNT_W-1:0]  cnt_reg_lo,
    input  logic              cnt_src,
    input  logic              force_zero,
    input  logic              mode_set,
    input  logic              mode_clr,
    input  logic              mode_load,
    input  logic              mode_load_val,
    output logic [OUT_W-1:0]  data_out,
    output logic              sign_mode
);
    logic [CNT_W-1:0] eff_cnt;
    logic             fill_bit;

    ss_mode_bit #(.RESET_VAL(1'b1)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (mode_set),
        .clr_i      (mode_clr),
        .load_i     (mode_load),
        .load_val_i (mode_load_val),
        .mode_o     (sign_mode)
    );

    ss_count_sel #(.CNT_W(CNT_W), .MAX_SHIFT(MAX_SHIFT)) u_cnt (
        .src_i (cnt_src_e'(cnt_src)),
        .imm_i (imm_cnt),
        .reg_i (cnt_reg_lo),
        .cnt_o (eff_cnt)
    );

    // Fill bit: the word's sign, only if sign mode is on and not overridden.
    always_comb begin
        fill_bit = sign_mode & ~force_zero & data_in[DATA_W-1];
    end

    ss_barrel #(.DATA_W(DATA_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_shift (
        .data_i (data_in),
        .fill_i (fill_bit),
        .cnt_i  (eff_cnt),
        .data_o (data_out)
    );
endmodule

// File: rtl/scaling_shifter_chk.sv
// scaling_shifter_chk: property checks on the scaling shifter, attached by bind.
module scaling_shifter_chk #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned OUT_W     = 32,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned MAX_SHIFT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_in,
    input logic [CNT_W-1:0]  imm_cnt,
    input logic [CNT_W-1:0]  cnt_reg_lo,
    input logic              cnt_src,
    input logic              force_zero,
    input logic              mode_set,
    input logic              mode_clr,
    input logic              mode_load,
    input logic              mode_load_val,
    input logic [OUT_W-1:0]  data_out,
    input logic              sign_mode
);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_SHIFT);
    localparam logic [CNT_W-1:0] EXT_LO = CNT_W'(OUT_W - DATA_W);

    logic [CNT_W-1:0] raw_c, eff_c;
    logic [OUT_W-1:0] low_mask, back;

    // Checker's own view of the effective count and derived views of the output.
    always_comb begin
        raw_c    = cnt_src ? cnt_reg_lo : imm_cnt;
        eff_c    = (raw_c > MAX_C) ? MAX_C : raw_c;
        low_mask = (OUT_W'(1) << eff_c) - OUT_W'(1);
        back     = data_out >> eff_c;
    end

    assert_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_out & low_mask) == '0);
    assert_word_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        back[DATA_W-1:0] == data_in);
    assert_sign_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_mode && !force_zero && eff_c < EXT_LO) |-> data_out[OUT_W-1] == data_in[DATA_W-1]);
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sign_mode && eff_c < EXT_LO) |-> !data_out[OUT_W-1]);
    assert_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_zero && eff_c < EXT_LO) |-> !data_out[OUT_W-1]);
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> sign_mode == $past(mode_load_val));
    assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_load && mode_set) |=> sign_mode);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_load && !mode_set && mode_clr) |=> !sign_mode);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_load && !mode_set && !mode_clr) |=> $stable(sign_mode));
    assert_old_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clr && !mode_set && !mode_load && sign_mode && !force_zero
         && data_in[DATA_W-1] && eff_c < EXT_LO) |-> data_out[OUT_W-1]);
endmodule

bind scaling_shifter scaling_shifter_chk #(
    .DATA_W(DATA_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .MAX_SHIFT(MAX_SHIFT)
) u_chk (.*);

// File: tb/test_scaling_shifter.sv
// test_scaling_shifter: sweeps counts, sources, modes and overrides against an arithmetic model.
module test_scaling_shifter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] data_in;
    logic [4:0]  imm_cnt, cnt_reg_lo;
    logic        cnt_src, force_zero;
    logic        mode_set, mode_clr, mode_load, mode_load_val;
    logic [31:0] data_out;
    logic        sign_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] pats [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h8001};

    always #(CLK_PERIOD/2) clk = ~clk;

    scaling_shifter i_scaling_shifter (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .imm_cnt(imm_cnt),
        .cnt_reg_lo(cnt_reg_lo), .cnt_src(cnt_src), .force_zero(force_zero),
        .mode_set(mode_set), .mode_clr(mode_clr), .mode_load(mode_load),
        .mode_load_val(mode_load_val), .data_out(data_out), .sign_mode(sign_mode)
    );

    function automatic logic [31:0] model(input logic [15:0] d, input logic m,
                                          input logic fz, input int c);
        int s;
        logic [31:0] e;
        s = (c > 16) ? 16 : c;
        e = (m && !fz && d[15]) ? {16'hFFFF, d} : {16'h0000, d};
        return e << s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mode_cycle(input logic s, input logic c, input logic l, input logic v);
        @(negedge clk);
        mode_set = s; mode_clr = c; mode_load = l; mode_load_val = v;
        @(posedge clk);
        #1;
        mode_set = 0; mode_clr = 0; mode_load = 0; mode_load_val = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; data_in = 0; imm_cnt = 0; cnt_reg_lo = 0; cnt_src = 0;
        force_zero = 0; mode_set = 0; mode_clr = 0; mode_load = 0; mode_load_val = 0;
        mode_cycle(0, 1, 0, 0);          // clear requested during reset: reset wins
        check("R7 reset", {31'd0, sign_mode}, 32'd1);
        @(negedge clk); rst_n = 1;

        mode_cycle(0, 1, 0, 0);
        check("R9 clear", {31'd0, sign_mode}, 32'd0);
        mode_cycle(0, 0, 0, 0);
        check("R10 hold 0", {31'd0, sign_mode}, 32'd0);
        mode_cycle(1, 1, 0, 0);
        check("R9 set beats clear", {31'd0, sign_mode}, 32'd1);
        mode_cycle(0, 0, 0, 0);
        check("R10 hold 1", {31'd0, sign_mode}, 32'd1);
        mode_cycle(1, 0, 1, 0);
        check("R8 load 0 over set", {31'd0, sign_mode}, 32'd0);
        mode_cycle(0, 1, 1, 1);
        check("R8 load 1 over clear", {31'd0, sign_mode}, 32'd1);

        // R11: clear and shift in the same cycle; the old mode governs this cycle.
        @(negedge clk);
        data_in = 16'h8000; cnt_src = 0; imm_cnt = 0; force_zero = 0; mode_clr = 1;
        #1;
        check("R11 before edge", data_out, 32'hFFFF8000);
        @(posedge clk); #1;
        mode_clr = 0;
        check("R11 after edge", data_out, 32'h00008000);

        // Sweep of R1-related behaviour over modes, override, sources and counts.
        for (int m = 0; m < 2; m++) begin
            mode_cycle(0, 0, 1, m[0]);
            check("R8 sweep load", {31'd0, sign_mode}, {31'd0, m[0]});
            for (int fz = 0; fz < 2; fz++) begin
                for (int src = 0; src < 2; src++) begin
                    for (int c = 0; c < 32; c++) begin
                        for (int p = 0; p < 8; p++) begin
                            @(negedge clk);
                            data_in = pats[p]; force_zero = fz[0]; cnt_src = src[0];
                            if (src == 1) begin
                                cnt_reg_lo = c[4:0]; imm_cnt = ~c[4:0];
                            end else begin
                                imm_cnt = c[4:0]; cnt_reg_lo = ~c[4:0];
                            end
                            #1;
                            if (c > 16)
                                check("R6 saturate", data_out, model(pats[p], m[0], fz[0], 16));
                            else if (fz == 1)
                                check("R4 override", data_out, model(pats[p], m[0], 1'b1, c));
                            else if (src == 1)
                                check("R5 reg source", data_out, model(pats[p], m[0], 1'b0, c));
                            else if (m == 1)
                                check("R2 sign fill", data_out, model(pats[p], 1'b1, 1'b0, c));
                            else
                                check("R3 zero fill", data_out, model(pats[p], 1'b0, 1'b0, c));
                        end
                    end
                end
            end
        end

        // R1 spot checks at the boundaries.
        @(negedge clk);
        data_in = 16'hFFFF; cnt_src = 0; imm_cnt = 5'd16; force_zero = 1; #1;
        check("R1 full shift", data_out, 32'hFFFF0000);
        @(negedge clk);
        imm_cnt = 5'd0; #1;
        check("R1 no shift", data_out, 32'h0000FFFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule